// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing of a display from a pixel clock. An X counter walks across each line and wraps at a programmed horizontal total. A Y counter advances on every X wrap and wraps at a programmed vertical total. Every timing output comes from its own pair of compare positions, one where it turns on and one where it turns off. A pair whose on point lies past its off point describes a window that wraps around the line end or the frame end. The signals are horizontal sync, vertical sync, horizontal blank, vertical blank, horizontal pixel enable, vertical pixel enable, and a horizontal and a vertical colour-lookup window.

Software writes the compare pairs, the totals and a flag word through a simple write port. The writes land in shadow registers. The whole set is copied into the working registers when the raster passes from the last pixel of a frame to the first, so a frame never mixes two configurations. The two sync outputs can be inverted individually for negative-polarity modes. A composite sync for the green channel can be switched off. A freeze input stops the counters, and a status output reports when they are stopped.

Software is expected to do the mode arithmetic itself. That includes the pipeline-compensating offsets on the blank edges and a pixel-enable window that wraps past the line end. The hardware only compares positions.

Top module: `vid_timing_gen`

## Requirements
- R1: After reset, pos_x and pos_y are 0. When freeze is low, pos_x increments by one on each clock. When it reaches htotal-1 it returns to 0 on the next clock. Totals are at least 1.
- R2: pos_y changes only on the clock where pos_x wraps. It then increments, except that it returns to 0 when it was vtotal-1.
- R3: While freeze is high, pos_x and pos_y hold their values. The frozen output equals the value freeze had on the previous clock edge (0 after reset).
- R4: A window whose on position is less than its off position is high exactly while its counter is in the range from on (inclusive) to off (exclusive).
- R5: A window whose on position is greater than its off position wraps: it is high while its counter is greater than or equal to on, or less than off.
- R6: A window whose on and off positions are equal is never high.
- R7: hsync, hblank, hpix_en and hcmap compare against pos_x. vsync, vblank, vpix_en and vcmap compare against pos_y.
- R8: Flag bit 0 inverts the hsync output and flag bit 1 inverts the vsync output.
- R9: sync_green is high when the raw (non-inverted) hsync window or the raw vsync window is high, unless flag bit 2 is set, in which case it stays low.
- R10: Written values take no effect until the clock edge on which the raster wraps from (htotal-1, vtotal-1) to (0,0). From that edge on, all of them apply together.
- R11: The register map is as follows. Each pair register holds on in cfg_wdata[CW-1:0] and off in cfg_wdata[2*CW-1:CW].
  - Address 0 holds the totals: htotal in the low CW bits, vtotal in the high CW bits.
  - Addresses 1 to 8 are the pairs for hsync, vsync, hblank, vblank, hpix_en, vpix_en, hcmap and vcmap, in that order.
  - Address 9 holds the flags in cfg_wdata[2:0].
  - Writes to any other address are ignored.
  - After reset the totals are DEF_HTOTAL and DEF_VTOTAL, and all pairs and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze | input | 1 | Holds the pixel counters while high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 2*CW | Register write data |
| pos_x | output | CW | Current horizontal position |
| pos_y | output | CW | Current vertical position |
| hsync | output | 1 | Horizontal sync after polarity flag |
| vsync | output | 1 | Vertical sync after polarity flag |
| hblank | output | 1 | Horizontal blank window |
| vblank | output | 1 | Vertical blank window |
| hpix_en | output | 1 | Horizontal pixel-enable window |
| vpix_en | output | 1 | Vertical pixel-enable window |
| hcmap | output | 1 | Horizontal colour-lookup window |
| vcmap | output | 1 | Vertical colour-lookup window |
| sync_green | output | 1 | Composite sync for the green channel |
| frozen | output | 1 | Counters are stopped |

## Verification
The bench builds the block with an 8-bit counter width and a reset raster of 10 by 4. This keeps frames to a few dozen cycles. Every clock can then be compared against an arithmetic model of the counters and the eight windows. The small width lets a sweep cover every on/off pairing on a 5 by 3 raster, including equal, normal and wrapped pairs and the line-end positions. It also brings within reach a degenerate 1 by 1 raster, configuration changes made mid-frame, and freezes of the counters.

// File: rtl/vtg_pkg.sv
// Shared constants for the raster timing generator.
// Assumes: window index i lives at register address i+1; even indices
// compare against X, odd indices against Y.
package vtg_pkg;
    localparam int NWIN     = 8;
    localparam int AW       = 4;
    localparam int NFLAGS   = 3;

    typedef enum logic [AW-1:0] {
        ADDR_TOTALS = 4'd0,
        ADDR_HSYNC  = 4'd1,
        ADDR_VSYNC  = 4'd2,
        ADDR_HBLANK = 4'd3,
        ADDR_VBLANK = 4'd4,
        ADDR_HPIXEN = 4'd5,
        ADDR_VPIXEN = 4'd6,
        ADDR_HCMAP  = 4'd7,
        ADDR_VCMAP  = 4'd8,
        ADDR_FLAGS  = 4'd9
    } vtg_addr_e;

    localparam int WIN_HSYNC  = 0;
    localparam int WIN_VSYNC  = 1;
    localparam int WIN_HBLANK = 2;
    localparam int WIN_VBLANK = 3;
    localparam int WIN_HPIXEN = 4;
    localparam int WIN_VPIXEN = 5;
    localparam int WIN_HCMAP  = 6;
    localparam int WIN_VCMAP  = 7;

    localparam int FLAG_INV_H  = 0;
    localparam int FLAG_INV_V  = 1;
    localparam int FLAG_SOG_OFF = 2;
endpackage

// File: rtl/vtg_counter.sv
// Pixel position counter: X wraps at htot, Y advances on each X wrap and
// wraps at vtot. Freeze holds both. Assumes totals are at least 1.
module vtg_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze,
    input  logic [CW-1:0] htot,
    input  logic [CW-1:0] vtot,
    output logic [CW-1:0] x,
    output logic [CW-1:0] y,
    output logic          frame_wrap,
    output logic          frozen
);
    logic x_last;
    logic y_last;

    assign x_last     = (x == htot - 1'b1);
    assign y_last     = (y == vtot - 1'b1);
    assign frame_wrap = x_last && y_last && !freeze;

    // Advance the raster position unless frozen; track freeze status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x      <= '0;
            y      <= '0;
            frozen <= 1'b0;
        end else begin
            frozen <= freeze;
            if (!freeze) begin
                if (x_last) begin
                    x <= '0;
                    y <= y_last ? '0 : y + 1'b1;
                end else begin
                    x <= x + 1'b1;
                end
            end
        end
    end

    assert_x_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !x_last) |=> (x == $past(x) + 1'b1));
    assert_x_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && x_last) |=> (x == '0));
    assert_y_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !x_last) |=> $stable(y));
    assert_freeze_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(x) && $stable(y) && frozen));
endmodule

// File: rtl/vtg_regs.sv
// Shadow and working register sets. Writes go to the shadow set; the
// whole shadow set is copied to the working set on the frame wrap.
// Assumes: unknown addresses are dropped silently.
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int CW          = 12,
    parameter int DEF_HTOTAL  = 800,
    parameter int DEF_VTOTAL  = 525,
    localparam int DW         = 2 * CW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     commit,
    output logic [CW-1:0]            htot,
    output logic [CW-1:0]            vtot,
    output logic [NWIN-1:0][CW-1:0]  win_on,
    output logic [NWIN-1:0][CW-1:0]  win_off,
    output logic [NFLAGS-1:0]        flags
);
    logic [DW-1:0]     sh_tot;
    logic [NFLAGS-1:0] sh_flags;
    logic [DW-1:0]     act_tot;
    logic [NFLAGS-1:0] act_flags;

    // Totals and flags: shadow write and frame-boundary commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tot    <= {CW'(DEF_VTOTAL), CW'(DEF_HTOTAL)};
            act_tot   <= {CW'(DEF_VTOTAL), CW'(DEF_HTOTAL)};
            sh_flags  <= '0;
            act_flags <= '0;
        end else begin
            if (commit) begin
                act_tot   <= sh_tot;
                act_flags <= sh_flags;
            end
            if (we && addr == ADDR_TOTALS) sh_tot   <= wdata;
            if (we && addr == ADDR_FLAGS)  sh_flags <= wdata[NFLAGS-1:0];
        end
    end

    assign htot  = act_tot[CW-1:0];
    assign vtot  = act_tot[DW-1:CW];
    assign flags = act_flags;

    for (genvar i = 0; i < NWIN; i++) begin : g_pair
        logic [DW-1:0] sh_pair;
        logic [DW-1:0] act_pair;

        // One compare pair: shadow write and frame-boundary commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_pair  <= '0;
                act_pair <= '0;
            end else begin
                if (commit) act_pair <= sh_pair;
                if (we && addr == AW'(i + 1)) sh_pair <= wdata;
            end
        end

        assign win_on[i]  = act_pair[CW-1:0];
        assign win_off[i] = act_pair[DW-1:CW];
    end

    assert_commit_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(win_on) && $stable(win_off) && $stable(htot)
                     && $stable(vtot) && $stable(flags)));
endmodule

// File: rtl/vtg_window.sv
// On/off comparator: high in [on, off) when on < off, in the wrapped
// range when on > off, never when on == off. Purely combinational.
module vtg_window #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] on_pos,
    input  logic [CW-1:0] off_pos,
    output logic          active
);
    logic past_on;
    logic before_off;

    assign past_on    = (pos >= on_pos);
    assign before_off = (pos < off_pos);

    // Select plain, wrapped or empty range from the pair ordering.
    always_comb begin
        if (on_pos < off_pos)      active = past_on && before_off;
        else if (on_pos > off_pos) active = past_on || before_off;
        else                       active = 1'b0;
    end
endmodule

// File: rtl/vid_timing_gen.sv
// Programmable raster timing generator top. Ties the counter, register
// sets and eight comparators together and applies sync polarity and the
// green-channel composite sync. Assumes software supplies totals >= 1.
module vid_timing_gen
    import vtg_pkg::*;
#(
    parameter int CW         = 12,
    parameter int DEF_HTOTAL = 800,
    parameter int DEF_VTOTAL = 525
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            freeze,
    input  logic            cfg_we,
    input  logic [3:0]      cfg_addr,
    input  logic [2*CW-1:0] cfg_wdata,
    output logic [CW-1:0]   pos_x,
    output logic [CW-1:0]   pos_y,
    output logic            hsync,
    output logic            vsync,
    output logic            hblank,
    output logic            vblank,
    output logic            hpix_en,
    output logic            vpix_en,
    output logic            hcmap,
    output logic            vcmap,
    output logic            sync_green,
    output logic            frozen
);
    logic [CW-1:0]           htot;
    logic [CW-1:0]           vtot;
    logic [NWIN-1:0][CW-1:0] win_on;
    logic [NWIN-1:0][CW-1:0] win_off;
    logic [NFLAGS-1:0]       flags;
    logic                    frame_wrap;
    logic [NWIN-1:0]         raw;

    vtg_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .freeze(freeze),
        .htot(htot), .vtot(vtot),
        .x(pos_x), .y(pos_y),
        .frame_wrap(frame_wrap), .frozen(frozen)
    );

    vtg_regs #(.CW(CW), .DEF_HTOTAL(DEF_HTOTAL), .DEF_VTOTAL(DEF_VTOTAL)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .commit(frame_wrap),
        .htot(htot), .vtot(vtot),
        .win_on(win_on), .win_off(win_off), .flags(flags)
    );

    for (genvar i = 0; i < NWIN; i++) begin : g_cmp
        vtg_window #(.CW(CW)) u_win (
            .pos((i % 2 == 0) ? pos_x : pos_y),
            .on_pos(win_on[i]),
            .off_pos(win_off[i]),
            .active(raw[i])
        );
    end

    assign hsync      = raw[WIN_HSYNC] ^ flags[FLAG_INV_H];
    assign vsync      = raw[WIN_VSYNC] ^ flags[FLAG_INV_V];
    assign hblank     = raw[WIN_HBLANK];
    assign vblank     = raw[WIN_VBLANK];
    assign hpix_en    = raw[WIN_HPIXEN];
    assign vpix_en    = raw[WIN_VPIXEN];
    assign hcmap      = raw[WIN_HCMAP];
    assign vcmap      = raw[WIN_VCMAP];
    assign sync_green = !flags[FLAG_SOG_OFF] && (raw[WIN_HSYNC] || raw[WIN_VSYNC]);

    assert_sog_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLAG_SOG_OFF] |-> !sync_green);
endmodule

// File: tb/vid_timing_gen_test.sv
`timescale 1ns/1ps
module vid_timing_gen_test;
    localparam int CW = 8;
    localparam int DH = 10;
    localparam int DV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          freeze = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [CW-1:0] pos_x, pos_y;
    logic hsync, vsync, hblank, vblank, hpix_en, vpix_en, hcmap, vcmap;
    logic sync_green, frozen;

    int n_tests = 0;
    int n_fail  = 0;
    string phase = "";

    always #4 clk = ~clk;

    vid_timing_gen #(.CW(CW), .DEF_HTOTAL(DH), .DEF_VTOTAL(DV)) uut (
        .clk(clk), .rst_n(rst_n), .freeze(freeze),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pos_x(pos_x), .pos_y(pos_y),
        .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
        .hpix_en(hpix_en), .vpix_en(vpix_en), .hcmap(hcmap), .vcmap(vcmap),
        .sync_green(sync_green), .frozen(frozen)
    );

    // Reference model built from the requirements.
    logic [15:0] m_sh  [10];
    logic [15:0] m_act [10];
    int m_x, m_y;
    logic m_frozen;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_x <= 0; m_y <= 0; m_frozen <= 1'b0;
            for (int i = 0; i < 10; i++) begin
                m_sh[i]  <= (i == 0) ? {8'(DV), 8'(DH)} : 16'h0;
                m_act[i] <= (i == 0) ? {8'(DV), 8'(DH)} : 16'h0;
            end
        end else begin
            m_frozen <= freeze;
            if (cfg_we && cfg_addr < 4'd10) m_sh[cfg_addr] <= cfg_wdata;
            if (!freeze) begin
                if (m_x == int'(m_act[0][7:0]) - 1) begin
                    m_x <= 0;
                    if (m_y == int'(m_act[0][15:8]) - 1) begin
                        m_y <= 0;
                        for (int i = 0; i < 10; i++) m_act[i] <= m_sh[i];
                    end else m_y <= m_y + 1;
                end else m_x <= m_x + 1;
            end
        end
    end

    function automatic logic win(int p, int on, int off);
        if (on < off) return (p >= on) && (p < off);
        if (on > off) return (p >= on) || (p < off);
        return 1'b0;
    endfunction

    function automatic logic ew(int i);
        return win((i % 2 == 0) ? m_x : m_y, int'(m_act[i+1][7:0]), int'(m_act[i+1][15:8]));
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (x=%0d y=%0d)", tag, phase, act, exp, m_x, m_y);
        end
    endtask

    task automatic check_all();
        chk("R1 pos_x", int'(pos_x), m_x);
        chk("R2 pos_y", int'(pos_y), m_y);
        chk("R3 frozen", int'(frozen), int'(m_frozen));
        chk("R8 hsync", int'(hsync), int'(ew(0) ^ m_act[9][0]));
        chk("R8 vsync", int'(vsync), int'(ew(1) ^ m_act[9][1]));
        chk("R4 R5 R6 R7 hblank", int'(hblank), int'(ew(2)));
        chk("R4 R5 R6 R7 vblank", int'(vblank), int'(ew(3)));
        chk("R4 R5 R6 R7 hpix_en", int'(hpix_en), int'(ew(4)));
        chk("R4 R5 R6 R7 vpix_en", int'(vpix_en), int'(ew(5)));
        chk("R4 R5 R6 R7 hcmap", int'(hcmap), int'(ew(6)));
        chk("R4 R5 R6 R7 vcmap", int'(vcmap), int'(ew(7)));
        chk("R9 sync_green", int'(sync_green), int'(!m_act[9][2] && (ew(0) || ew(1))));
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] pk(int on, int off);
        return {8'(off), 8'(on)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // Reset state (R1, R3, R11 defaults).
        phase = "reset";
        repeat (3) @(negedge clk);
        check_all();
        rst_n = 1'b1;
        phase = "default R1 R2";
        step(45);

        // Config A written mid-frame; old values hold until the wrap (R10).
        phase = "R10 config A";
        wr(0, {8'd6, 8'd12});
        wr(1, pk(7, 9));
        wr(2, pk(4, 5));
        wr(3, pk(8, 11));
        wr(4, pk(4, 6));
        wr(5, pk(10, 6));
        wr(6, pk(0, 4));
        wr(7, pk(3, 3));
        wr(8, pk(5, 1));
        wr(15, 16'hFFFF);   // R11 unknown address ignored
        step(60);
        phase = "config A";
        step(150);

        // Freeze mid-line (R3).
        phase = "R3 freeze";
        freeze = 1'b1;
        step(7);
        freeze = 1'b0;
        step(20);

        // Config B: wrapped windows, inverted syncs, green sync off.
        phase = "R8 R9 config B";
        wr(0, {8'd3, 8'd7});
        wr(1, pk(5, 2));
        wr(2, pk(2, 1));
        wr(3, pk(6, 0));
        wr(4, pk(2, 2));
        wr(9, 16'h0007);
        wr(14, 16'h0000);   // R11 unknown address ignored
        step(120);

        // Degenerate 1x1 raster.
        phase = "R1 R2 degenerate";
        wr(0, {8'd1, 8'd1});
        wr(1, pk(0, 1));
        wr(2, pk(0, 0));
        wr(9, 16'h0001);
        step(40);
        freeze = 1'b1;
        step(3);
        freeze = 1'b0;
        step(5);

        // Sweep every on/off pairing on a 5x3 raster (R4 R5 R6 R7).
        phase = "R4 R5 R6 sweep";
        wr(0, {8'd3, 8'd5});
        for (int on = 0; on < 6; on++) begin
            for (int off = 0; off < 6; off++) begin
                wr(1, pk(on, off));
                wr(2, pk(on % 4, off % 4));
                wr(3, pk(off, on));
                wr(6, pk(off % 4, on % 4));
                wr(9, 16'(on % 8));
                if ((on + off) % 7 == 3) begin
                    freeze = 1'b1;
                    step(2);
                    freeze = 1'b0;
                end
                step(30);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule